// File: doc/BRIEF.md
# Memory-Indirect Nibble AND Unit

This unit carries out a read-modify-write logical AND on a 4-bit data memory. The CPU's sequencer presents a 13-bit opcode with a one-cycle `start` strobe. When the opcode belongs to the AND-to-memory group, the unit reads the nibble at an effective address, ANDs it with one of two 4-bit data registers, and writes the result back to the same address. In the same cycle it reports the new flag word and, for the pointer-advancing forms, the incremented index value. The CPU owns the register file and applies the `idx_we` and `flags_we` write strobes.

A separate one-shot extension strobe (`ext_load` with an 8-bit immediate) arms a pending address override. The next accepted plain form then goes to a fixed page: page 0000H when X is the index, page FF00H when Y is the index. The pointer-advancing forms ignore the override, but they still consume it.

The controller is a three-state machine. `ST_IDLE` waits for a start strobe. `ST_READ` drives the address and the read strobe. `ST_WRITE` drives the write strobe and the result, and pulses `done`. The transitions are: IDLE→READ on an accepted start; READ→WRITE always; WRITE→READ on an accepted start; WRITE→IDLE otherwise. The memory is synchronous: read data arrives on the clock edge after the read strobe.

Top module: `andm_unit`

## Requirements
- R1: Only opcodes whose upper ten bits are 1101001101 (codes 1A68H..1A6FH) are accepted. Any other opcode is ignored: no memory strobe follows, and a pending extension stays armed.
- R2: In the cycle after an accepted start, `mem_rd` is 1, `mem_wr` is 0 and `mem_addr` holds the effective address.
- R3: In the cycle after the read, `mem_wr` and `done` are 1, `mem_addr` is unchanged and `mem_wdata` equals the read nibble ANDed with the data register. Opcode bit 2 selects that register: 0 selects `reg_a`, 1 selects `reg_b`.
- R4: Opcode bit 1 selects the index register: 0 selects `reg_x`, 1 selects `reg_y`. `idx_sel` reports the choice.
- R5: When opcode bit 0 is 1, the write cycle asserts `idx_we` with `idx_wdata` = index + 1 modulo 2^16, so FFFFH becomes 0000H. When bit 0 is 0, `idx_we` stays 0.
- R6: The write cycle asserts `flags_we`. Bit 0 of `flags_out` (zero) is 1 exactly when the result is 0000. Bits 3..1 (extension, interrupt, carry) equal `flags_in[3:1]` as sampled at start.
- R7: `ext_load` arms an override. The next accepted form with bit 0 = 0 uses address 00xxH when X is selected and FFxxH when Y is selected, where xx is the immediate.
- R8: Forms with bit 0 = 1 use the index register even when an override is armed. Any accepted instruction clears the override.
- R9: `ready` is 1 in IDLE and WRITE and 0 in READ. A start accepted in WRITE enters READ on the next cycle with no idle gap.
- R10: After reset the unit is idle: `ready` = 1, all strobes are 0, and no override is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction issue strobe |
| opcode | input | 13 | Instruction code |
| ready | output | 1 | Start can be accepted this cycle |
| ext_load | input | 1 | Arm the address override |
| ext_imm | input | 8 | Override low byte |
| reg_a | input | 4 | Data register A |
| reg_b | input | 4 | Data register B |
| reg_x | input | 16 | Index register X |
| reg_y | input | 16 | Index register Y |
| flags_in | input | 4 | Current flags {E,I,C,Z} |
| mem_addr | output | 16 | Data memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 4 | Write data |
| mem_rdata | input | 4 | Read data, one cycle after `mem_rd` |
| idx_we | output | 1 | Index register write enable |
| idx_sel | output | 1 | Index written: 0 X, 1 Y |
| idx_wdata | output | 16 | Incremented index value |
| flags_we | output | 1 | Flag write enable |
| flags_out | output | 4 | New flags {E,I,C,Z} |
| done | output | 1 | Instruction completes this cycle |

## Verification
A stuck or skipped controller state shows up one cycle after start, as a missing read strobe or a `ready` that should have dropped. A lost transition to the write state shows up one cycle later, as a missing write or `done`. A wrong latched operand or effective address shows up within two cycles, in `mem_addr` or `mem_wdata`. A stale or wrongly cleared override stays hidden until the next plain form issues, so the bench always follows prefix, reset and ignored-opcode cases with such a form. Back-to-back issue checks that the write-to-read path loses no cycle.

// File: rtl/andm_pkg.sv
package andm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } andm_state_e;

    typedef struct packed {
        logic legal;
        logic use_b;
        logic use_y;
        logic post_inc;
    } andm_op_s;

endpackage

// File: rtl/andm_decode.sv
module andm_decode
    import andm_pkg::*;
#(
    parameter int OPW = 13,
    parameter logic [OPW-1:0] OP_BASE = 13'h1A68
) (
    input  logic [OPW-1:0] opcode,
    output andm_op_s       op
);
    localparam int VB = 3;

    always_comb begin
        op.legal    = (opcode[OPW-1:VB] == OP_BASE[OPW-1:VB]);
        op.use_b    = opcode[2];
        op.use_y    = opcode[1];
        op.post_inc = opcode[0];
    end
endmodule

// File: rtl/andm_agen.sv
module andm_agen #(
    parameter int AW   = 16,
    parameter int IMMW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_load,
    input  logic [IMMW-1:0] ext_imm,
    input  logic            consume,
    input  logic            use_y,
    input  logic            post_inc,
    input  logic [AW-1:0]   idx_val,
    output logic [AW-1:0]   ea,
    output logic            pending
);
    localparam int PW = AW - IMMW;

    logic [IMMW-1:0] imm_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            imm_q   <= '0;
        end else if (ext_load) begin
            pending <= 1'b1;
            imm_q   <= ext_imm;
        end else if (consume) begin
            pending <= 1'b0;
        end
    end

    always_comb begin
        if (pending && !post_inc)
            ea = use_y ? {{PW{1'b1}}, imm_q} : {{PW{1'b0}}, imm_q};
        else
            ea = idx_val;
    end

    p_ext_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_load |=> pending);
    p_pending_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !ext_load) |=> !pending);
endmodule

// File: rtl/andm_ctrl.sv
module andm_ctrl
    import andm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic legal,
    output logic accept,
    output logic ready,
    output logic mem_rd,
    output logic mem_wr,
    output logic done
);
    andm_state_e state, state_nx;

    assign accept = start && legal && (state != ST_READ);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = ST_READ;
            ST_READ:  state_nx = ST_WRITE;
            ST_WRITE: state_nx = accept ? ST_READ : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        ready  = 1'b1;
        mem_rd = 1'b0;
        mem_wr = 1'b0;
        done   = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_READ:  begin ready = 1'b0; mem_rd = 1'b1; end
            ST_WRITE: begin mem_wr = 1'b1; done = 1'b1; end
            default:  ;
        endcase
    end

    p_rd_to_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);
    p_wr_after_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd));
    p_busy_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !ready);
    p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
endmodule

// File: rtl/andm_unit.sv
module andm_unit
    import andm_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 4,
    parameter int IMMW = 8,
    parameter int OPW  = 13,
    parameter int FW   = 4,
    parameter logic [OPW-1:0] OP_BASE = 13'h1A68
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [OPW-1:0]  opcode,
    output logic            ready,
    input  logic            ext_load,
    input  logic [IMMW-1:0] ext_imm,
    input  logic [DW-1:0]   reg_a,
    input  logic [DW-1:0]   reg_b,
    input  logic [AW-1:0]   reg_x,
    input  logic [AW-1:0]   reg_y,
    input  logic [FW-1:0]   flags_in,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic            idx_we,
    output logic            idx_sel,
    output logic [AW-1:0]   idx_wdata,
    output logic            flags_we,
    output logic [FW-1:0]   flags_out
    ,output logic           done
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    andm_op_s       dec;
    logic           accept;
    logic [AW-1:0]  idx_val;
    logic [AW-1:0]  ea;
    logic           pending;

    logic [AW-1:0]  r_addr;
    logic [AW-1:0]  r_idx;
    logic [DW-1:0]  r_data;
    logic [FW-1:1]  r_flags;
    logic           r_inc;
    logic           r_usey;
    logic [DW-1:0]  result;

    andm_decode #(.OPW(OPW), .OP_BASE(OP_BASE)) u_dec (
        .opcode (opcode),
        .op     (dec)
    );

    assign idx_val = dec.use_y ? reg_y : reg_x;

    andm_agen #(.AW(AW), .IMMW(IMMW)) u_agen (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_load (ext_load),
        .ext_imm  (ext_imm),
        .consume  (accept),
        .use_y    (dec.use_y),
        .post_inc (dec.post_inc),
        .idx_val  (idx_val),
        .ea       (ea),
        .pending  (pending)
    );

    andm_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .legal  (dec.legal),
        .accept (accept),
        .ready  (ready),
        .mem_rd (mem_rd),
        .mem_wr (mem_wr),
        .done   (done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_addr  <= '0;
            r_idx   <= '0;
            r_data  <= '0;
            r_flags <= '0;
            r_inc   <= 1'b0;
            r_usey  <= 1'b0;
        end else if (accept) begin
            r_addr  <= ea;
            r_idx   <= idx_val;
            r_data  <= dec.use_b ? reg_b : reg_a;
            r_flags <= flags_in[FW-1:1];
            r_inc   <= dec.post_inc;
            r_usey  <= dec.use_y;
        end
    end

    assign result    = mem_rdata & r_data;
    assign mem_addr  = r_addr;
    assign mem_wdata = result;
    assign idx_we    = mem_wr && r_inc;
    assign idx_sel   = r_usey;
    assign idx_wdata = r_idx + ONE;
    assign flags_we  = mem_wr;
    assign flags_out = {r_flags, (result == '0)};

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $stable(mem_addr));
    p_inc_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        idx_we |-> (idx_wdata == mem_addr + ONE));
    p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> (flags_out[0] == (mem_wdata == '0)));
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!mem_rd && !mem_wr && !pending));
endmodule

// File: tb/sim_andm_unit.sv
module sim_andm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [12:0] opcode = '0;
    logic        ready;
    logic        ext_load = 1'b0;
    logic [7:0]  ext_imm = '0;
    logic [3:0]  reg_a = '0, reg_b = '0;
    logic [15:0] reg_x = '0, reg_y = '0;
    logic [3:0]  flags_in = '0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [3:0]  mem_wdata;
    logic [3:0]  mem_rdata = '0;
    logic        idx_we, idx_sel;
    logic [15:0] idx_wdata;
    logic        flags_we;
    logic [3:0]  flags_out;
    logic        done;

    int errors = 0;
    int checks = 0;
    bit bpend = 1'b0;
    logic [7:0] bimm = '0;
    logic [3:0] mem [0:65535];

    always #2 clk = ~clk;

    andm_unit u0 (.*);

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_wr) mem[mem_addr] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_ea(input logic [12:0] op);
        if (bpend && !op[0]) return op[1] ? {8'hFF, bimm} : {8'h00, bimm};
        return op[1] ? reg_y : reg_x;
    endfunction

    task automatic prefix(input logic [7:0] imm);
        ext_load = 1'b1; ext_imm = imm;
        @(negedge clk);
        ext_load = 1'b0;
        bpend = 1'b1; bimm = imm;
    endtask

    // called at a negedge with the unit ready; returns in its write cycle
    task automatic exec(input logic [12:0] op);
        logic [15:0] ea, idx;
        logic [3:0]  res;
        logic [3:0]  fl;
        bit legal;
        legal = (op[12:3] == 10'b1101001101);
        ea  = exp_ea(op);
        idx = op[1] ? reg_y : reg_x;
        fl  = flags_in;
        res = op[2] ? reg_b : reg_a;
        start = 1'b1; opcode = op;
        @(negedge clk);
        start = 1'b0;
        if (!legal) begin
            chk(mem_rd == 1'b0, "R1 ignored opcode read", 32'(mem_rd), 0);
            chk(ready == 1'b1, "R1 ignored opcode ready", 32'(ready), 1);
            return;
        end
        chk(mem_rd == 1'b1 && mem_wr == 1'b0, "R2 read strobe", 32'({mem_rd, mem_wr}), 2);
        chk(mem_addr == ea, "R2 R4 R7 R8 address", 32'(mem_addr), 32'(ea));
        chk(ready == 1'b0, "R9 busy in read", 32'(ready), 0);
        res = mem[ea] & res;
        bpend = 1'b0;
        @(negedge clk);
        chk(mem_wr && done, "R3 write and done", 32'({mem_wr, done}), 3);
        chk(mem_addr == ea, "R3 address held", 32'(mem_addr), 32'(ea));
        chk(mem_wdata == res, "R3 AND result", 32'(mem_wdata), 32'(res));
        chk(idx_we == op[0], "R5 index write enable", 32'(idx_we), 32'(op[0]));
        if (op[0]) begin
            chk(idx_wdata == idx + 16'd1, "R5 incremented index", 32'(idx_wdata), 32'(idx + 16'd1));
            chk(idx_sel == op[1], "R4 index select", 32'(idx_sel), 32'(op[1]));
        end
        chk(flags_we && flags_out == {fl[3:1], res == 4'd0}, "R6 flags",
            32'({flags_we, flags_out}), 32'({1'b1, fl[3:1], res == 4'd0}));
        chk(ready == 1'b1, "R9 ready in write", 32'(ready), 1);
        flags_in = {fl[3:1], res == 4'd0};
        if (op[0]) begin
            if (op[1]) reg_y = reg_y + 16'd1;
            else       reg_x = reg_x + 16'd1;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        bpend = 1'b0;
        chk(ready && !mem_rd && !mem_wr && !done && !idx_we && !flags_we,
            "R10 reset state", 32'({ready, mem_rd, mem_wr, done}), 32'h8);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 65536; i++) mem[i] = 4'($urandom);
        @(negedge clk);
        do_reset();

        // R10: override armed before reset is gone afterwards
        prefix(8'h3C);
        do_reset();
        reg_x = 16'h1234;
        exec(13'h1A68);
        @(negedge clk);

        // R7: X page and Y page overrides
        reg_x = 16'h4000; reg_a = 4'hF;
        prefix(8'h34);
        exec(13'h1A68);
        @(negedge clk);
        reg_y = 16'h5000; reg_b = 4'h6;
        prefix(8'hA5);
        exec(13'h1A6E);
        @(negedge clk);

        // R8: increment form ignores an armed override and clears it
        reg_x = 16'h0777;
        prefix(8'h11);
        exec(13'h1A69);
        exec(13'h1A68);   // R9 back to back, must use index again
        @(negedge clk);

        // R1: foreign opcode ignored and override kept
        prefix(8'h22);
        exec(13'h1A70);
        exec(13'h0A68);
        exec(13'h1A6A);
        @(negedge clk);

        // R5: wrap from FFFF, both index registers
        reg_x = 16'hFFFF; reg_y = 16'hFFFF;
        exec(13'h1A69);
        chk(idx_wdata == 16'h0000, "R5 X wrap", 32'(idx_wdata), 0);
        exec(13'h1A6F);
        chk(idx_wdata == 16'h0000, "R5 Y wrap", 32'(idx_wdata), 0);
        @(negedge clk);

        // R6: zero result with E, I, C set
        flags_in = 4'b1110; reg_a = 4'h0; reg_x = 16'h0100;
        exec(13'h1A68);
        chk(flags_out == 4'b1111, "R6 zero flag set, others kept", 32'(flags_out), 32'hF);
        @(negedge clk);

        // R9: back-to-back on the same address sees the new value
        reg_x = 16'h0200; reg_a = 4'h5; reg_b = 4'h3;
        exec(13'h1A68);
        exec(13'h1A6C);
        @(negedge clk);

        for (int i = 0; i < 80; i++) begin
            logic [12:0] op;
            reg_a = 4'($urandom); reg_b = 4'($urandom);
            reg_x = ($urandom % 5 == 0) ? 16'hFFFF : 16'($urandom);
            reg_y = 16'($urandom);
            flags_in = 4'($urandom);
            if ($urandom % 4 == 0) prefix(8'($urandom));
            if ($urandom % 3 == 0) @(negedge clk);
            op = {10'b1101001101, 3'($urandom)};
            if ($urandom % 10 == 0) op = 13'($urandom);
            exec(op);
        end
        @(negedge clk);
        chk(ready && !mem_rd && !mem_wr, "R9 idle after last", 32'(ready), 1);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule